// File: doc/BRIEF.md
# Inverter Gate Fault Guard

This block sits between a PWM generator and the gate drivers of a three-phase inverter bridge with six switches. Each phase has one high-side and one low-side switch, and each takes an active-high command. The block also watches several digitised supply and current flags:

- an over-current flag for the low-side return path;
- a pair of under-voltage flags (below-trip and above-restore) for the low-side control supply;
- the same pair of flags for each high-side bootstrap supply.

From these it produces six gated enables, an active-low fault line shared by both low-side fault sources, and a status code that names the source of the latest fault.

A low-side fault (over-current or supply loss) blanks all three low-side switches and pulls the fault line low for a guaranteed minimum time. A low-side supply loss keeps the line low for as long as the supply stays invalid. A high-side supply loss blanks only the switch of its own phase and leaves the fault line alone. After any blanking, a switch returns only on a fresh low-to-high edge of its command, so a command that stays high does not turn the switch back on.

Every input passes through a two-flop synchroniser before it is used. All outputs are registered. All control pins are plain levels, so the block has no streaming interface and no back-pressure.

Top module: `invgate_guard`

## Requirements
- R1: A command change appears on its gate output at the third rising clock edge after it is applied, made up of two synchroniser stages and one output register.
- R2: The synchronous active-low reset drives all gates to 0, the fault line high and the status to 2'b00. A command that is held high through reset does not turn its gate on until it goes low and then high again.
- R3: When the synchronised over-current flag is high, all three low-side gates go to 0 on the same edge, and the fault line goes low on that edge too.
- R4: One over-current sample holds the fault line low for exactly FAULT_CYC cycles. The default is 10000 cycles, which is 40 µs at 250 MHz.
- R5: A further over-current sample while the fault line is low restarts the full FAULT_CYC window from that sample.
- R6: While the fault line is low, the low-side gates stay at 0. After it releases, a low-side gate turns on only after a fresh rising edge of its command.
- R7: A low-side under-voltage trip blanks all low-side gates and pulls the fault line low. The line stays low for at least FAULT_CYC cycles, even when the trip lasts one cycle and the restore flag follows at once.
- R8: After a low-side trip, the fault stays active until the restore flag is seen with the trip flag low. The trip flag falling on its own does not end the fault.
- R9: A trip on high-side supply i forces only hi_gate[i] to 0 and leaves the fault line high. That gate re-arms only on a command rising edge after restore flag i is seen.
- R10: Over-current events leave the high-side gates unchanged.
- R11: fault_src reads 2'b01 after an over-current and 2'b10 after a low-side under-voltage trip. When both arrive on the same edge, over-current wins. The value holds until the next fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hi_cmd | input | 3 | High-side PWM commands, one per phase |
| lo_cmd | input | 3 | Low-side PWM commands, one per phase |
| oc_flag | input | 1 | Low-side over-current comparator flag |
| lo_uv_trip | input | 1 | Low-side supply below trip level |
| lo_uv_ok | input | 1 | Low-side supply above restore level |
| hi_uv_trip | input | 3 | Bootstrap supply below trip level, per phase |
| hi_uv_ok | input | 3 | Bootstrap supply above restore level, per phase |
| hi_gate | output | 3 | Gated high-side enables |
| lo_gate | output | 3 | Gated low-side enables |
| fault_n | output | 1 | Shared fault line, active low |
| fault_src | output | 2 | Source of latest fault: 00 none, 01 over-current, 10 under-voltage |

## Verification
Two things can land on the same edge: an over-current sample and a low-side under-voltage trip. The bench raises both flags in the same cycle and expects three results on one edge: fault_src at 01, the fault line low, and the low-side gates blanked. It then releases the supply and checks that the line stays low until the timer has run out. The bench also provokes a fresh over-current while the pulse is already running, and judges the restart by the exact cycle in which the line is released.

// File: rtl/invgate_pkg.sv
package invgate_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_OC   = 2'b01,
    SRC_UV   = 2'b10
  } fault_src_e;
endpackage

// File: rtl/invgate_sync2.sv
// Two-flop synchroniser bank with a per-bit reset value.
module invgate_sync2 #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/invgate_uv_hyst.sv
// Per-supply under-voltage latch: set by trip, cleared by restore.
module invgate_uv_hyst #(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] trip,
  input  logic [N-1:0] restore,
  output logic [N-1:0] active_nxt,
  output logic [N-1:0] active
);
  for (genvar i = 0; i < N; i++) begin : g_sup
    always_comb begin
      if (trip[i])         active_nxt[i] = 1'b1;
      else if (restore[i]) active_nxt[i] = 1'b0;
      else                 active_nxt[i] = active[i];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) active[i] <= 1'b0;
      else        active[i] <= active_nxt[i];
    end
  end
endmodule

// File: rtl/invgate_pulse_timer.sv
// Minimum-width fault stretcher; a start sample reloads the full window.
module invgate_pulse_timer #(
  parameter int FAULT_CYC = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic hold,
  output logic fault_nxt
);
  localparam int CW = $clog2(FAULT_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(FAULT_CYC);

  logic [CW-1:0] cnt, cnt_nxt;

  always_comb begin
    if (start)           cnt_nxt = LOAD;
    else if (cnt != '0)  cnt_nxt = cnt - 1'b1;
    else                 cnt_nxt = '0;
    fault_nxt = start | hold | (cnt_nxt != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end
endmodule

// File: rtl/invgate_rearm.sv
// Per-channel gate register; re-arms only on a command rising edge
// seen while the channel is not blocked.
module invgate_rearm #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cmd,
  input  logic [N-1:0] block,
  output logic [N-1:0] gate
);
  logic [N-1:0] cmd_d, armed, armed_nxt;

  for (genvar i = 0; i < N; i++) begin : g_ch
    always_comb begin
      if (block[i]) armed_nxt[i] = 1'b0;
      else          armed_nxt[i] = armed[i] | (cmd[i] & ~cmd_d[i]);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmd_d[i] <= 1'b1;
        armed[i] <= 1'b0;
        gate[i]  <= 1'b0;
      end else begin
        cmd_d[i] <= cmd[i];
        armed[i] <= armed_nxt[i];
        gate[i]  <= armed_nxt[i] & cmd[i];
      end
    end
  end
endmodule

// File: rtl/invgate_guard.sv
module invgate_guard
  import invgate_pkg::*;
#(
  parameter int NPH       = 3,
  parameter int FAULT_CYC = 10000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NPH-1:0] hi_cmd,
  input  logic [NPH-1:0] lo_cmd,
  input  logic           oc_flag,
  input  logic           lo_uv_trip,
  input  logic           lo_uv_ok,
  input  logic [NPH-1:0] hi_uv_trip,
  input  logic [NPH-1:0] hi_uv_ok,
  output logic [NPH-1:0] hi_gate,
  output logic [NPH-1:0] lo_gate,
  output logic           fault_n,
  output logic [1:0]     fault_src
);
  localparam int CMDW  = 2 * NPH;
  localparam int FLAGW = 3 + 2 * NPH;

  logic [CMDW-1:0]  cmd_s;
  logic [FLAGW-1:0] flag_s;
  logic             oc_s, lo_trip_s, lo_ok_s;
  logic [NPH-1:0]   hi_trip_s, hi_ok_s;

  // Commands reset high so a level held across reset is not an edge.
  invgate_sync2 #(.W(CMDW), .RST_VAL({CMDW{1'b1}})) u_cmd_sync (
    .clk(clk), .rst_n(rst_n), .d({hi_cmd, lo_cmd}), .q(cmd_s)
  );

  invgate_sync2 #(.W(FLAGW), .RST_VAL({FLAGW{1'b0}})) u_flag_sync (
    .clk(clk), .rst_n(rst_n),
    .d({hi_uv_ok, hi_uv_trip, lo_uv_ok, lo_uv_trip, oc_flag}),
    .q(flag_s)
  );

  assign oc_s      = flag_s[0];
  assign lo_trip_s = flag_s[1];
  assign lo_ok_s   = flag_s[2];
  assign hi_trip_s = flag_s[3 +: NPH];
  assign hi_ok_s   = flag_s[3 + NPH +: NPH];

  // Low-side supply latch
  logic lo_uv_nxt, lo_uv_q;
  invgate_uv_hyst #(.N(1)) u_lo_uv (
    .clk(clk), .rst_n(rst_n), .trip(lo_trip_s), .restore(lo_ok_s),
    .active_nxt(lo_uv_nxt), .active(lo_uv_q)
  );

  // High-side bootstrap latches, one per phase
  logic [NPH-1:0] hi_uv_nxt, hi_uv_q;
  invgate_uv_hyst #(.N(NPH)) u_hi_uv (
    .clk(clk), .rst_n(rst_n), .trip(hi_trip_s), .restore(hi_ok_s),
    .active_nxt(hi_uv_nxt), .active(hi_uv_q)
  );

  // Shared fault window
  logic lo_fault_nxt;
  invgate_pulse_timer #(.FAULT_CYC(FAULT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .start(oc_s | lo_trip_s), .hold(lo_uv_nxt),
    .fault_nxt(lo_fault_nxt)
  );

  // Gate channels
  invgate_rearm #(.N(NPH)) u_lo_gate (
    .clk(clk), .rst_n(rst_n), .cmd(cmd_s[NPH-1:0]),
    .block({NPH{lo_fault_nxt}}), .gate(lo_gate)
  );

  invgate_rearm #(.N(NPH)) u_hi_gate (
    .clk(clk), .rst_n(rst_n), .cmd(cmd_s[CMDW-1:NPH]),
    .block(hi_uv_nxt), .gate(hi_gate)
  );

  // Fault line and source status
  fault_src_e src_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_n <= 1'b1;
      src_q   <= SRC_NONE;
    end else begin
      fault_n <= ~lo_fault_nxt;
      if (oc_s)           src_q <= SRC_OC;
      else if (lo_trip_s) src_q <= SRC_UV;
    end
  end

  assign fault_src = src_q;
endmodule

// File: rtl/invgate_guard_chk.sv
module invgate_guard_chk #(
  parameter int NPH       = 3,
  parameter int FAULT_CYC = 10000
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NPH-1:0] lo_gate,
  input logic           fault_n,
  input logic [1:0]     fault_src
);
  localparam int CW = $clog2(FAULT_CYC + 2);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                low_cnt <= '0;
    else if (fault_n)          low_cnt <= '0;
    else if (low_cnt != '1)    low_cnt <= low_cnt + 1'b1;
  end

  // R6: the low-side switches stay blanked while the fault line is active
  a_r6_lo_off_in_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n |-> (lo_gate == '0));

  // R4: the fault line never releases before its minimum width
  a_r4_min_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_n) |-> (low_cnt >= CW'(FAULT_CYC)));

  // R11: the status code is one of the defined values
  a_r11_src_code: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fault_src));

  // R11: an active fault always has a recorded source
  a_r11_src_known: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n |-> (fault_src != 2'b00));
endmodule

bind invgate_guard invgate_guard_chk #(.NPH(NPH), .FAULT_CYC(FAULT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .lo_gate(lo_gate),
  .fault_n(fault_n), .fault_src(fault_src)
);

// File: tb/invgate_guard_test.sv
`timescale 1ns/1ps
module invgate_guard_test;
  localparam int NPH = 3;
  localparam int FC  = 10000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] hi_cmd = '0, lo_cmd = '0, hi_uv_trip = '0, hi_uv_ok = '0;
  logic oc_flag = 1'b0, lo_uv_trip = 1'b0, lo_uv_ok = 1'b0;
  logic [2:0] hi_gate, lo_gate;
  logic fault_n;
  logic [1:0] fault_src;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  invgate_guard #(.NPH(NPH), .FAULT_CYC(FC)) uut (
    .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd),
    .oc_flag(oc_flag), .lo_uv_trip(lo_uv_trip), .lo_uv_ok(lo_uv_ok),
    .hi_uv_trip(hi_uv_trip), .hi_uv_ok(hi_uv_ok),
    .hi_gate(hi_gate), .lo_gate(lo_gate),
    .fault_n(fault_n), .fault_src(fault_src)
  );

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic arm_lo();
    lo_cmd = 3'b000; cyc(3);
    lo_cmd = 3'b111; cyc(3);
  endtask

  task automatic arm_hi();
    hi_cmd = 3'b000; cyc(3);
    hi_cmd = 3'b111; cyc(3);
  endtask

  task automatic t_reset();
    lo_cmd = 3'b111; hi_cmd = 3'b111; rst_n = 1'b0;
    cyc(5);
    rst_n = 1'b1;
    cyc(10);
    check("R2 lo_gate held-high after reset", {5'b0, lo_gate}, 8'h0);
    check("R2 hi_gate held-high after reset", {5'b0, hi_gate}, 8'h0);
    check("R2 fault_n reset", {7'b0, fault_n}, 8'h1);
    check("R2 fault_src reset", {6'b0, fault_src}, 8'h0);
    arm_lo(); arm_hi();
    check("R2 lo_gate after fresh edge", {5'b0, lo_gate}, 8'h7);
  endtask

  task automatic t_latency();
    lo_cmd = 3'b000; cyc(3);
    lo_cmd = 3'b001; cyc(2);
    check("R1 no change after two edges", {5'b0, lo_gate}, 8'h0);
    cyc(1);
    check("R1 change on third edge", {5'b0, lo_gate}, 8'h1);
    lo_cmd = 3'b111; cyc(3);
  endtask

  task automatic t_oc();
    arm_lo(); arm_hi();
    oc_flag = 1'b1; cyc(1); oc_flag = 1'b0; cyc(2);
    check("R3 low gates blanked", {5'b0, lo_gate}, 8'h0);
    check("R3 fault asserted", {7'b0, fault_n}, 8'h0);
    check("R10 high gates untouched", {5'b0, hi_gate}, 8'h7);
    check("R11 source over-current", {6'b0, fault_src}, 8'h1);
    cyc(FC - 1);
    check("R4 still low at last cycle", {7'b0, fault_n}, 8'h0);
    check("R6 low gates off during fault", {5'b0, lo_gate}, 8'h0);
    cyc(1);
    check("R4 released after window", {7'b0, fault_n}, 8'h1);
    cyc(5);
    check("R6 held-high stays off", {5'b0, lo_gate}, 8'h0);
    arm_lo();
    check("R6 re-armed by fresh edge", {5'b0, lo_gate}, 8'h7);
  endtask

  task automatic t_restart();
    oc_flag = 1'b1; cyc(1); oc_flag = 1'b0; cyc(2);
    cyc(100);
    oc_flag = 1'b1; cyc(1); oc_flag = 1'b0; cyc(2);
    cyc(FC - 1);
    check("R5 window restarted", {7'b0, fault_n}, 8'h0);
    cyc(1);
    check("R5 released after restarted window", {7'b0, fault_n}, 8'h1);
    arm_lo();
  endtask

  task automatic t_uv_long();
    lo_uv_trip = 1'b1; cyc(3); lo_uv_trip = 1'b0;
    check("R7 low gates blanked by trip", {5'b0, lo_gate}, 8'h0);
    check("R7 fault on trip", {7'b0, fault_n}, 8'h0);
    check("R11 source under-voltage", {6'b0, fault_src}, 8'h2);
    check("R10 high gates untouched by low trip", {5'b0, hi_gate}, 8'h7);
    cyc(FC + 50);
    check("R8 fault held until restore", {7'b0, fault_n}, 8'h0);
    lo_uv_ok = 1'b1; cyc(1); lo_uv_ok = 1'b0; cyc(1);
    check("R8 fault one edge before restore seen", {7'b0, fault_n}, 8'h0);
    cyc(1);
    check("R7 fault released after restore", {7'b0, fault_n}, 8'h1);
    check("R6 low gates stay off after restore", {5'b0, lo_gate}, 8'h0);
    arm_lo();
    check("R6 low gates re-armed after supply return", {5'b0, lo_gate}, 8'h7);
  endtask

  task automatic t_uv_short();
    lo_uv_trip = 1'b1; cyc(1); lo_uv_trip = 1'b0; lo_uv_ok = 1'b1; cyc(2);
    check("R7 short trip asserts fault", {7'b0, fault_n}, 8'h0);
    cyc(FC - 1);
    check("R7 short trip still at minimum width", {7'b0, fault_n}, 8'h0);
    cyc(1);
    check("R7 short trip releases after minimum", {7'b0, fault_n}, 8'h1);
    lo_uv_ok = 1'b0;
    arm_lo();
  endtask

  task automatic t_hi_uv();
    hi_uv_trip = 3'b010; cyc(3);
    check("R9 only phase 1 high gate off", {5'b0, hi_gate}, 8'h5);
    check("R9 fault line silent", {7'b0, fault_n}, 8'h1);
    check("R9 low gates unaffected", {5'b0, lo_gate}, 8'h7);
    hi_uv_trip = 3'b000; cyc(5);
    check("R9 stays off until restore", {5'b0, hi_gate}, 8'h5);
    hi_uv_ok = 3'b010; cyc(1); hi_uv_ok = 3'b000; cyc(5);
    check("R9 no re-arm without edge", {5'b0, hi_gate}, 8'h5);
    hi_cmd = 3'b101; cyc(3); hi_cmd = 3'b111; cyc(3);
    check("R9 re-armed by fresh edge", {5'b0, hi_gate}, 8'h7);
    check("R9 fault line still silent", {7'b0, fault_n}, 8'h1);
  endtask

  task automatic t_both();
    oc_flag = 1'b1; lo_uv_trip = 1'b1; cyc(1);
    oc_flag = 1'b0; lo_uv_trip = 1'b0; cyc(2);
    check("R11 same-edge sources pick over-current", {6'b0, fault_src}, 8'h1);
    check("R3 same-edge fault asserted", {7'b0, fault_n}, 8'h0);
    check("R3 same-edge low gates blanked", {5'b0, lo_gate}, 8'h0);
    lo_uv_ok = 1'b1; cyc(3); lo_uv_ok = 1'b0;
    check("R4 timer still holds after restore", {7'b0, fault_n}, 8'h0);
    cyc(FC);
    check("R4 same-edge fault released", {7'b0, fault_n}, 8'h1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_oc();
    t_restart();
    t_uv_long();
    t_uv_short();
    t_hi_uv();
    t_both();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule